// File: doc/BRIEF.md
# Configurable IQ Output Formatter

This block sits at the end of a filter chain. It takes an in-phase and a quadrature sample, offered together with a one-cycle valid strobe. It passes the pair on as parallel words or shifts it out as serial bit streams. Static configuration inputs choose the output form. They set whether serial I and Q use two lines or share one line with I sent first, which end of the word leaves first, two's complement or offset binary coding, the active level of the data-ready output, which way the serial clock swings at mid-bit, and a bit rate of the system clock divided by 1, 2, 4 or 8.

In serial mode one pair becomes one frame. While a frame is being sent, any further pair is thrown away and a sticky overrun flag records the loss. The serial clock starts each bit at its idle level and swings away from it halfway through the bit. Data therefore changes only on the opposite swing, and a receiver can take each bit on the mid-bit swing. The configuration inputs are meant to be changed only while no frame is in progress.

Top module: `iq_out_fmt`

## Requirements
- R1: After reset, overrun is 0, par_i and par_q are 0, sdat_i and sdat_q are 0, rdy is at its inactive level, and sclk rests at its idle level, which equals cfg_sclk_inv.
- R2: With cfg_serial=0, a sample pair offered with in_valid appears on par_i/par_q on the next clock edge. rdy is active for exactly that one cycle, and par_i/par_q hold their value while in_valid is low.
- R3: With cfg_offset_bin=1, the MSB of every output word (parallel or serial) is inverted relative to the two's complement input. With 0 the word passes unchanged.
- R4: rdy is active high when cfg_rdy_low=0 and active low when cfg_rdy_low=1, in both parallel and serial mode.
- R5: With cfg_serial=1 and cfg_seq=0, a frame is SAMPLE_W bit periods long. In each period sdat_i carries a bit of I and sdat_q the bit of Q at the same position.
- R6: With cfg_serial=1 and cfg_seq=1, a frame is 2*SAMPLE_W bit periods on sdat_i: all of I first, then all of Q. sdat_q stays 0.
- R7: cfg_msb_first=1 sends bit SAMPLE_W-1 of each word first. cfg_msb_first=0 sends bit 0 first.
- R8: The bit period is 2^cfg_rate system clocks (cfg_rate 0,1,2,3 gives 1,2,4,8 clocks). The first bit period starts at the clock edge that accepts the pair.
- R9: During a bit, sclk equals cfg_sclk_inv in the first half and its inverse in the second half. With cfg_rate=0 the second half is the low phase of the system clock. Outside a frame, sclk equals cfg_sclk_inv, and serial data changes only at bit starts.
- R10: In serial mode, rdy is active for the whole first bit period of each frame and inactive for the rest of the frame and while idle.
- R11: A pair offered in serial mode while a frame is in progress is dropped: the frame goes on unchanged and overrun becomes 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Sample pair strobe |
| in_i | input | SAMPLE_W | In-phase sample, two's complement |
| in_q | input | SAMPLE_W | Quadrature sample, two's complement |
| cfg_serial | input | 1 | 1 serial, 0 parallel |
| cfg_seq | input | 1 | 1 I then Q on sdat_i, 0 separate lines |
| cfg_msb_first | input | 1 | 1 MSB first, 0 LSB first |
| cfg_offset_bin | input | 1 | 1 offset binary output, 0 two's complement |
| cfg_rdy_low | input | 1 | 1 rdy active low, 0 active high |
| cfg_sclk_inv | input | 1 | 1 high-to-low at mid-bit, 0 low-to-high |
| cfg_rate | input | 2 | Bit period of 2^cfg_rate clocks |
| par_i | output | SAMPLE_W | Parallel in-phase word |
| par_q | output | SAMPLE_W | Parallel quadrature word |
| rdy | output | 1 | Data ready / frame marker |
| sclk | output | 1 | Serial bit clock |
| sdat_i | output | 1 | Serial I (or I then Q) data |
| sdat_q | output | 1 | Serial Q data |
| overrun | output | 1 | Sticky dropped-pair flag |

## Verification
The bench builds the block with SAMPLE_W=8. This keeps the longest frame (interleaved, divide by eight) at 128 clocks, so every combination of lane mode, bit order and rate can be walked bit by bit. At eight bits, sign-bit patterns such as 0x80 and 0x7F are easy to tell apart from the MSB inversion. The I-to-Q lane switch in interleaved mode falls early enough to be checked in every bit period.

// File: rtl/iq_fmt_pkg.sv
package iq_fmt_pkg;
  typedef enum logic {ST_IDLE, ST_SHIFT} fmt_state_e;
  localparam int RATE_W = 2;
  localparam int CNT_W  = 3;
endpackage

// File: rtl/iq_fmt_conv.sv
module iq_fmt_conv #(
  parameter int W = 16
) (
  input  logic [W-1:0] din,
  input  logic         offset_bin,
  output logic [W-1:0] dout
);
  localparam logic [W-1:0] SIGN_MASK = {1'b1, {(W-1){1'b0}}};

  always_comb begin
    dout = offset_bin ? (din ^ SIGN_MASK) : din;
  end
endmodule

// File: rtl/iq_fmt_timer.sv
module iq_fmt_timer
  import iq_fmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              bit_end,
  output logic              half_next
);
  logic [CNT_W-1:0] cnt_q, cnt_d, last;
  logic             cnt_en;

  always_comb begin
    last    = CNT_W'((4'd1 << rate) - 4'd1);
    bit_end = run && (cnt_q == last);
    cnt_en  = start || run;
    cnt_d   = cnt_q;
    if (start)        cnt_d = '0;
    else if (bit_end) cnt_d = '0;
    else if (run)     cnt_d = cnt_q + 1'b1;
    case (rate)
      2'd0:    half_next = 1'b0;
      2'd1:    half_next = cnt_d[0];
      2'd2:    half_next = cnt_d[1];
      default: half_next = cnt_d[2];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/iq_fmt_lane.sv
module iq_fmt_lane #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic         msb_first,
  input  logic [W-1:0] din,
  output logic         bit_out
);
  logic [W-1:0] sr_q, sr_d;
  logic         sr_en;

  always_comb begin
    sr_en = load || shift;
    if (load)           sr_d = din;
    else if (msb_first) sr_d = {sr_q[W-2:0], 1'b0};
    else                sr_d = {1'b0, sr_q[W-1:1]};
    bit_out = msb_first ? sr_q[W-1] : sr_q[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end
endmodule

// File: rtl/iq_out_fmt.sv
module iq_out_fmt
  import iq_fmt_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_i,
  input  logic [SAMPLE_W-1:0] in_q,
  input  logic                cfg_serial,
  input  logic                cfg_seq,
  input  logic                cfg_msb_first,
  input  logic                cfg_offset_bin,
  input  logic                cfg_rdy_low,
  input  logic                cfg_sclk_inv,
  input  logic [1:0]          cfg_rate,
  output logic [SAMPLE_W-1:0] par_i,
  output logic [SAMPLE_W-1:0] par_q,
  output logic                rdy,
  output logic                sclk,
  output logic                sdat_i,
  output logic                sdat_q,
  output logic                overrun
);
  localparam int W      = SAMPLE_W;
  localparam int BIDX_W = $clog2(2 * W);
  localparam logic [BIDX_W-1:0] LAST_SIM = BIDX_W'(W - 1);
  localparam logic [BIDX_W-1:0] LAST_SEQ = BIDX_W'(2 * W - 1);
  localparam logic [BIDX_W-1:0] Q_START  = BIDX_W'(W);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  // number format conversion
  logic [W-1:0] fmt_i, fmt_q;

  iq_fmt_conv #(.W(W)) u_conv_i (.din(in_i), .offset_bin(cfg_offset_bin), .dout(fmt_i));
  iq_fmt_conv #(.W(W)) u_conv_q (.din(in_q), .offset_bin(cfg_offset_bin), .dout(fmt_q));

  // control state
  fmt_state_e        state_q, state_d;
  logic [BIDX_W-1:0] bidx_q, bidx_d;
  logic              busy_q, busy_d;
  logic              accept_ser, accept_par, bit_end, half_next;
  logic              lane_sel, last_bit, shift_i, shift_q;
  logic              ovr_q, ovr_d;
  logic              par_rdy_q;
  logic              raw_clk_q, raw_clk_d, raw_clk;
  logic              bit_i, bit_q;
  logic              rdy_act;
  logic [W-1:0]      par_i_q, par_q_q;

  always_comb begin
    busy_q     = (state_q == ST_SHIFT);
    accept_ser = cfg_serial && in_valid && !busy_q;
    accept_par = !cfg_serial && in_valid;
    lane_sel   = cfg_seq && (bidx_q >= Q_START);
    last_bit   = bidx_q == (cfg_seq ? LAST_SEQ : LAST_SIM);
    state_d    = state_q;
    bidx_d     = bidx_q;
    if (accept_ser) begin
      state_d = ST_SHIFT;
      bidx_d  = '0;
    end else if (bit_end) begin
      if (last_bit) state_d = ST_IDLE;
      else          bidx_d  = bidx_q + 1'b1;
    end
    busy_d    = (state_d == ST_SHIFT);
    shift_i   = bit_end && (!cfg_seq || !lane_sel);
    shift_q   = bit_end && (!cfg_seq || lane_sel);
    ovr_d     = ovr_q || (cfg_serial && in_valid && busy_q);
    raw_clk_d = busy_d && half_next;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q   <= ST_IDLE;
      bidx_q    <= '0;
      ovr_q     <= 1'b0;
      par_rdy_q <= 1'b0;
      raw_clk_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      bidx_q    <= bidx_d;
      ovr_q     <= ovr_d;
      par_rdy_q <= accept_par;
      raw_clk_q <= raw_clk_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      par_i_q <= '0;
      par_q_q <= '0;
    end else if (accept_par) begin
      par_i_q <= fmt_i;
      par_q_q <= fmt_q;
    end
  end

  // bit timing and serial lanes
  iq_fmt_timer u_timer (
    .clk(clk), .rst_n(rst_i_n), .start(accept_ser), .run(busy_q),
    .rate(cfg_rate), .bit_end(bit_end), .half_next(half_next)
  );

  iq_fmt_lane #(.W(W)) u_lane_i (
    .clk(clk), .rst_n(rst_i_n), .load(accept_ser), .shift(shift_i),
    .msb_first(cfg_msb_first), .din(fmt_i), .bit_out(bit_i)
  );

  iq_fmt_lane #(.W(W)) u_lane_q (
    .clk(clk), .rst_n(rst_i_n), .load(accept_ser), .shift(shift_q),
    .msb_first(cfg_msb_first), .din(fmt_q), .bit_out(bit_q)
  );

  // outputs; at full rate the second bit half is the low clock phase
  always_comb begin
    raw_clk = (cfg_rate == 2'd0) ? (busy_q && !clk) : raw_clk_q;
    rdy_act = par_rdy_q || (busy_q && (bidx_q == '0));
    sclk    = raw_clk ^ cfg_sclk_inv;
    rdy     = rdy_act ^ cfg_rdy_low;
    sdat_i  = busy_q && (lane_sel ? bit_q : bit_i);
    sdat_q  = busy_q && !cfg_seq && bit_q;
    par_i   = par_i_q;
    par_q   = par_q_q;
    overrun = ovr_q;
  end
endmodule

// File: rtl/iq_fmt_chk.sv
module iq_fmt_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         cfg_serial,
  input logic         cfg_rdy_low,
  input logic         cfg_sclk_inv,
  input logic [W-1:0] par_i,
  input logic [W-1:0] par_q,
  input logic         rdy,
  input logic         sclk,
  input logic         overrun,
  input logic         busy
);
  assert_overrun_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  assert_overrun_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> ($past(in_valid) && $past(busy)));

  assert_drop_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_serial && in_valid && busy) |=> overrun);

  assert_par_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(par_i) && $stable(par_q)));

  assert_par_rdy_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_serial && (rdy != cfg_rdy_low)) |-> $past(in_valid));

  assert_idle_sclk_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == cfg_sclk_inv));
endmodule

bind iq_out_fmt iq_fmt_chk #(.W(SAMPLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cfg_serial(cfg_serial),
  .cfg_rdy_low(cfg_rdy_low), .cfg_sclk_inv(cfg_sclk_inv), .par_i(par_i),
  .par_q(par_q), .rdy(rdy), .sclk(sclk), .overrun(overrun), .busy(busy_q)
);

// File: tb/tb_iq_out_fmt.sv
module tb_iq_out_fmt;
  localparam int W = 8;

  logic         clk, rst_n, in_valid;
  logic [W-1:0] in_i, in_q;
  logic         cfg_serial, cfg_seq, cfg_msb_first, cfg_offset_bin;
  logic         cfg_rdy_low, cfg_sclk_inv;
  logic [1:0]   cfg_rate;
  logic [W-1:0] par_i, par_q;
  logic         rdy, sclk, sdat_i, sdat_q, overrun;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  iq_out_fmt #(.SAMPLE_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .cfg_serial(cfg_serial), .cfg_seq(cfg_seq), .cfg_msb_first(cfg_msb_first),
    .cfg_offset_bin(cfg_offset_bin), .cfg_rdy_low(cfg_rdy_low),
    .cfg_sclk_inv(cfg_sclk_inv), .cfg_rate(cfg_rate), .par_i(par_i), .par_q(par_q),
    .rdy(rdy), .sclk(sclk), .sdat_i(sdat_i), .sdat_q(sdat_q), .overrun(overrun)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] fmt(input logic [W-1:0] x, input logic off);
    fmt = off ? {~x[W-1], x[W-2:0]} : x;
  endfunction

  task automatic configure(input logic ser, input logic seq, input logic msb,
                           input logic off, input logic rlow, input logic inv,
                           input logic [1:0] rate);
    @(negedge clk);
    cfg_serial = ser; cfg_seq = seq; cfg_msb_first = msb;
    cfg_offset_bin = off; cfg_rdy_low = rlow; cfg_sclk_inv = inv; cfg_rate = rate;
  endtask

  // R1
  task automatic test_reset();
    @(negedge clk);
    chk("R1 overrun", 32'(overrun), 0);
    chk("R1 par_i", 32'(par_i), 0);
    chk("R1 par_q", 32'(par_q), 0);
    chk("R1 sdat_i", 32'(sdat_i), 0);
    chk("R1 sdat_q", 32'(sdat_q), 0);
    chk("R1 rdy inactive", 32'(rdy), 32'(cfg_rdy_low));
    chk("R1 sclk idle", 32'(sclk), 32'(cfg_sclk_inv));
  endtask

  // R2, R3, R4
  task automatic test_parallel(input logic [W-1:0] vi, input logic [W-1:0] vq,
                               input logic off, input logic rlow);
    configure(1'b0, 1'b0, 1'b1, off, rlow, 1'b0, 2'd0);
    in_i = vi; in_q = vq; in_valid = 1'b1;
    @(posedge clk); #5;
    in_valid = 1'b0;
    chk("R2/R3 par_i", 32'(par_i), 32'(fmt(vi, off)));
    chk("R2/R3 par_q", 32'(par_q), 32'(fmt(vq, off)));
    chk("R2/R4 rdy active", 32'(rdy), 32'(!rlow));
    in_i = ~vi; in_q = ~vq;
    @(posedge clk); #5;
    chk("R2/R4 rdy one cycle", 32'(rdy), 32'(rlow));
    chk("R2 par_i hold", 32'(par_i), 32'(fmt(vi, off)));
    chk("R2 par_q hold", 32'(par_q), 32'(fmt(vq, off)));
    chk("R9 sclk idle in parallel", 32'(sclk), 0);
  endtask

  // R3..R11 serial frame, walked one system clock at a time
  task automatic test_serial(input logic [W-1:0] vi, input logic [W-1:0] vq,
                             input logic seq, input logic msb, input logic off,
                             input logic rlow, input logic inv, input logic [1:0] rate,
                             input logic inject);
    logic [W-1:0] fi, fq;
    int p, nb;
    fi = fmt(vi, off); fq = fmt(vq, off);
    p = 1 << rate;
    nb = seq ? 2 * W : W;
    configure(1'b1, seq, msb, off, rlow, inv, rate);
    in_i = vi; in_q = vq; in_valid = 1'b1;
    for (int k = 0; k < nb * p; k++) begin
      int b, c, j, idx;
      logic lane, e_i, e_q, raw;
      @(posedge clk); #5;
      if (k == 0) in_valid = 1'b0;
      if (inject && k == 2) begin
        in_i = ~vi; in_q = ~vq; in_valid = 1'b1;
      end
      if (inject && k == 3) in_valid = 1'b0;
      b = k / p; c = k % p;
      lane = seq && (b >= W);
      j = lane ? b - W : b;
      idx = msb ? W - 1 - j : j;
      e_i = lane ? fq[idx] : fi[idx];
      e_q = seq ? 1'b0 : fq[idx];
      raw = (p > 1) && (c >= p / 2);
      chk(seq ? "R6/R7/R3 sdat_i" : "R5/R7/R3 sdat_i", 32'(sdat_i), 32'(e_i));
      chk(seq ? "R6 sdat_q quiet" : "R5/R7 sdat_q", 32'(sdat_q), 32'(e_q));
      chk("R8/R9 sclk", 32'(sclk), 32'(raw ^ inv));
      chk("R10/R4 rdy", 32'(rdy), 32'((b == 0) ^ rlow));
      if (rate == 2'd0) begin
        @(negedge clk); #2;
        chk("R9 sclk low phase at full rate", 32'(sclk), 32'(!inv));
      end
    end
    @(posedge clk); #5;
    chk("R8 frame end sdat_i", 32'(sdat_i), 0);
    chk("R9 frame end sclk idle", 32'(sclk), 32'(inv));
    chk("R10 frame end rdy", 32'(rdy), 32'(rlow));
    chk("R11 overrun", 32'(overrun), 32'(inject));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0; in_i = '0; in_q = '0;
    cfg_serial = 1'b0; cfg_seq = 1'b0; cfg_msb_first = 1'b1;
    cfg_offset_bin = 1'b0; cfg_rdy_low = 1'b0; cfg_sclk_inv = 1'b0; cfg_rate = 2'd0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    test_reset();
    test_parallel(8'h35, 8'hC2, 1'b0, 1'b0);
    test_parallel(8'h7F, 8'h80, 1'b1, 1'b1);
    test_serial(8'hA5, 8'h3C, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
    test_serial(8'h81, 8'h7E, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd1, 1'b0);
    test_serial(8'hC3, 8'h19, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0);
    test_serial(8'h5A, 8'hE4, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd3, 1'b0);
    test_serial(8'h96, 8'h0F, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0);
    test_serial(8'h2D, 8'hB1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 1'b1);
    test_serial(8'h66, 8'h99, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1);
    do_reset();
    test_reset();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule